// File: doc/BRIEF.md
# Busy-Polling Character Display Host Driver

This block is the host-side bus master for a parallel character-display controller with an 8-bit data bus. A requester hands it one request at a time over a valid/ready handshake. Each request is either a command write, a data write, a data read or a status read. Before every command or data transfer, the driver reads the controller's status byte until the busy flag is clear. Only then does it run the transfer, driving the register select, the read/write line, an enable strobe with programmable setup, high and hold times, and the data bus. The data bus is released during reads.

Each accepted request produces exactly one response. The response carries the read byte and a timeout flag. If too many consecutive status reads report busy, the request ends with a timeout and no transfer takes place. Polling can be switched off per request. In that case the driver skips the status reads and instead holds off the next request for a fixed delay after each transfer. Clear and return-home commands get the long delay and every other transfer gets the short one. The most recent status byte, holding the busy flag and the address counter, is always visible on an output.

Top module: `lcd_host_drv`

## Requirements
- R1: After reset, req_ready_o=1, lcd_en_o=0, lcd_db_oe_o=0, lcd_rw_o=1, rsp_valid_o=0 and status_o=0x00.
- R2: Bus line codes follow the request type: command write RS=0/RW=0, data write RS=1/RW=0, data read RS=1/RW=1, status read RS=0/RW=1. During every strobe lcd_db_oe_o equals the inverse of lcd_rw_o. RS, RW and the data bus stay stable while the strobe is high, and a write drives the request byte.
- R3: With polling enabled, each non-status request is preceded by status reads until one returns DB7=0. The number of status reads equals the number of busy replies plus one, and no transfer starts while the controller is busy.
- R4: With polling enabled, POLL_MAX consecutive busy replies end the request. The driver then emits a response with rsp_timeout_o=1 and rsp_data_o=0x00, and makes no transfer strobe. POLL_MAX-1 busy replies still succeed.
- R5: The enable strobe is high for exactly t_high_i+1 cycles.
- R6: Consecutive status-read strobes within one request rise exactly t_setup_i+t_high_i+t_hold_i+4 cycles apart.
- R7: With polling disabled, no status read precedes the transfer. req_ready_o rises D+2 cycles after the response cycle. D is LONG_DLY for commands 0x01, 0x02 and 0x03, 0 for a status read, and SHORT_DLY for everything else, including data bytes of those values.
- R8: With polling enabled, and also after a timeout, req_ready_o rises one cycle after the response cycle.
- R9: A data read returns the byte sampled from lcd_db_i during the strobe on rsp_data_o. A write returns 0x00.
- R10: A status-read request makes exactly one strobe with no polling and returns the status byte on rsp_data_o. status_o holds the byte from the last status read of any kind.
- R11: Requests are accepted only while req_ready_o=1. req_ready_o is low whenever rsp_valid_o is high, and each accepted request yields exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Driver idle, request accepted on valid |
| req_rs_i | input | 1 | Register select of the request (0 command/status, 1 data) |
| req_rw_i | input | 1 | 1 read, 0 write |
| req_data_i | input | 8 | Byte to write |
| poll_en_i | input | 1 | 1 poll busy flag, 0 use fixed delays; sampled at acceptance |
| t_setup_i | input | CW | Setup cycles minus one before strobe rise |
| t_high_i | input | CW | Strobe high cycles minus one |
| t_hold_i | input | CW | Hold cycles minus one after strobe fall |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | 8 | Read byte (0 for writes and timeouts) |
| rsp_timeout_o | output | 1 | Request ended on poll limit |
| status_o | output | 8 | Last status byte read (busy flag, address counter) |
| lcd_rs_o | output | 1 | Register select to display |
| lcd_rw_o | output | 1 | Read/write line to display |
| lcd_en_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data bus output value |
| lcd_db_oe_o | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus input value |

## Verification
The hardest case to reach from the ports is the poll-limit boundary. The busy flag must stay set for exactly POLL_MAX replies in one run and exactly POLL_MAX-1 replies in another. The bench's display model therefore arms a programmable number of busy replies after every transfer and counts them down on each status strobe. A preceding write then sets the exact busy run that the next request meets. The same model sweeps busy runs of zero to three across all 27 small timing settings, while monitors measure strobe widths and poll spacing.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_HOLD} bus_ph_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_GO, ST_POLL_WAIT, ST_XFER_GO, ST_XFER_WAIT, ST_DLY
  } drv_st_e;

  // clear (0x01) and return home (0x02/0x03) need the long settle time
  function automatic logic is_long_cmd(logic rs, logic rw, logic [7:0] code);
    return !rs && !rw && (code[7:2] == 6'd0) && (code[1:0] != 2'd0);
  endfunction
endpackage

// File: rtl/lcd_bus_cycle.sv
module lcd_bus_cycle
  import lcd_host_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic [7:0]    wdata_i,
  input  logic [CW-1:0] t_setup_i,
  input  logic [CW-1:0] t_high_i,
  input  logic [CW-1:0] t_hold_i,
  input  logic [7:0]    db_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic          rs_o,
  output logic          rw_o,
  output logic          en_o,
  output logic [7:0]    db_o,
  output logic          oe_o
);
  bus_ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  logic          rs_q, rw_q;
  logic [7:0]    wd_q, rd_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rs_q  <= 1'b0;
      rw_q  <= 1'b1;
      wd_q  <= 8'h00;
      rd_q  <= 8'h00;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= t_setup_i;
          rs_q  <= rs_i;
          rw_q  <= rw_i;
          wd_q  <= rw_i ? 8'h00 : wdata_i;
        end
        PH_SETUP: if (!cnt_zero) cnt_q <= cnt_q - CW'(1);
                  else begin ph_q <= PH_HIGH; cnt_q <= t_high_i; end
        PH_HIGH:  if (!cnt_zero) cnt_q <= cnt_q - CW'(1);
                  else begin ph_q <= PH_HOLD; cnt_q <= t_hold_i; rd_q <= db_i; end
        PH_HOLD:  if (!cnt_zero) cnt_q <= cnt_q - CW'(1);
                  else ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o  = (ph_q == PH_HOLD) && cnt_zero;
  assign rdata_o = rd_q;
  assign rs_o    = rs_q;
  assign rw_o    = rw_q;
  assign en_o    = (ph_q == PH_HIGH);
  assign db_o    = wd_q;
  assign oe_o    = (ph_q != PH_IDLE) && !rw_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (ph_q == PH_IDLE)); // R11
  AST_BUS_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && $past(en_o)) |-> ($stable(db_o) && $stable(rs_o) && $stable(rw_o) && $stable(oe_o))); // R2
endmodule

// File: rtl/lcd_dly_timer.sv
module lcd_dly_timer #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] val_i,
  output logic          expired_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - DW'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_host_drv.sv
module lcd_host_drv
  import lcd_host_pkg::*;
#(
  parameter int CW        = 4,
  parameter int LONG_DLY  = 76000,
  parameter int SHORT_DLY = 1850,
  parameter int POLL_MAX  = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_rs_i,
  input  logic          req_rw_i,
  input  logic [7:0]    req_data_i,
  input  logic          poll_en_i,
  input  logic [CW-1:0] t_setup_i,
  input  logic [CW-1:0] t_high_i,
  input  logic [CW-1:0] t_hold_i,
  output logic          rsp_valid_o,
  output logic [7:0]    rsp_data_o,
  output logic          rsp_timeout_o,
  output logic [7:0]    status_o,
  output logic          lcd_rs_o,
  output logic          lcd_rw_o,
  output logic          lcd_en_o,
  output logic [7:0]    lcd_db_o,
  output logic          lcd_db_oe_o,
  input  logic [7:0]    lcd_db_i
);
  localparam int DW  = $clog2(LONG_DLY + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);

  drv_st_e        state_q;
  logic           rs_q, rw_q, poll_q;
  logic [7:0]     data_q, status_q;
  logic [PCW-1:0] poll_cnt_q;

  logic       eng_start, eng_rs, eng_rw, eng_done;
  logic [7:0] eng_rdata;
  logic       status_req, poll_done, poll_last, timeout_hit, xfer_done;
  logic       dly_load, dly_expired;
  logic [DW-1:0] dly_val;

  assign status_req  = !rs_q && rw_q;
  assign eng_start   = (state_q == ST_POLL_GO) || (state_q == ST_XFER_GO);
  assign eng_rs      = (state_q == ST_POLL_GO) ? 1'b0 : rs_q;
  assign eng_rw      = (state_q == ST_POLL_GO) ? 1'b1 : rw_q;
  assign poll_done   = (state_q == ST_POLL_WAIT) && eng_done;
  assign poll_last   = (poll_cnt_q == PCW'(POLL_MAX - 1));
  assign timeout_hit = poll_done && eng_rdata[7] && poll_last;
  assign xfer_done   = (state_q == ST_XFER_WAIT) && eng_done;
  assign dly_load    = xfer_done && !poll_q;

  always_comb begin
    if (is_long_cmd(rs_q, rw_q, data_q)) dly_val = DW'(LONG_DLY);
    else if (status_req)                 dly_val = '0;
    else                                 dly_val = DW'(SHORT_DLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rs_q       <= 1'b0;
      rw_q       <= 1'b0;
      poll_q     <= 1'b0;
      data_q     <= 8'h00;
      status_q   <= 8'h00;
      poll_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          rs_q       <= req_rs_i;
          rw_q       <= req_rw_i;
          data_q     <= req_data_i;
          poll_q     <= poll_en_i;
          poll_cnt_q <= '0;
          state_q    <= (poll_en_i && !(!req_rs_i && req_rw_i)) ? ST_POLL_GO : ST_XFER_GO;
        end
        ST_POLL_GO: state_q <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (eng_done) begin
          status_q <= eng_rdata;
          if (!eng_rdata[7])  state_q <= ST_XFER_GO;
          else if (poll_last) state_q <= ST_IDLE;
          else begin
            poll_cnt_q <= poll_cnt_q + PCW'(1);
            state_q    <= ST_POLL_GO;
          end
        end
        ST_XFER_GO: state_q <= ST_XFER_WAIT;
        ST_XFER_WAIT: if (eng_done) begin
          if (status_req) status_q <= eng_rdata;
          state_q <= poll_q ? ST_IDLE : ST_DLY;
        end
        ST_DLY: if (dly_expired) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lcd_bus_cycle #(.CW(CW)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .rs_i      (eng_rs),
    .rw_i      (eng_rw),
    .wdata_i   (data_q),
    .t_setup_i (t_setup_i),
    .t_high_i  (t_high_i),
    .t_hold_i  (t_hold_i),
    .db_i      (lcd_db_i),
    .done_o    (eng_done),
    .rdata_o   (eng_rdata),
    .rs_o      (lcd_rs_o),
    .rw_o      (lcd_rw_o),
    .en_o      (lcd_en_o),
    .db_o      (lcd_db_o),
    .oe_o      (lcd_db_oe_o)
  );

  lcd_dly_timer #(.DW(DW)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dly_load),
    .val_i     (dly_val),
    .expired_o (dly_expired)
  );

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rsp_valid_o   = xfer_done || timeout_hit;
  assign rsp_timeout_o = timeout_hit;
  assign rsp_data_o    = (xfer_done && rw_q) ? eng_rdata : 8'h00;
  assign status_o      = status_q;

  AST_WRITE_AFTER_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER_GO && poll_q && !status_req) |-> !status_q[7]); // R3
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_cnt_q < PCW'(POLL_MAX)); // R4
  AST_DLY_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) == ST_DLY) |-> $past(dly_expired)); // R7
  AST_RSP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R11
endmodule

// File: tb/lcd_host_drv_bench.sv
module lcd_host_drv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LONG  = 40;
  localparam int SHORT = 12;
  localparam int PMAX  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_rs_i = 1'b0, req_rw_i = 1'b0, poll_en_i = 1'b1;
  logic [7:0] req_data_i = 8'h00;
  logic [3:0] tsu = 4'd1, thi = 4'd2, tho = 4'd1;
  logic req_ready_o, rsp_valid_o, rsp_timeout_o;
  logic [7:0] rsp_data_o, status_o, lcd_db_o, lcd_db_i;
  logic lcd_rs_o, lcd_rw_o, lcd_en_o, lcd_db_oe_o;

  int cyc = 0;
  int tests = 0, fails = 0;
  int busy_n = 0;
  logic [7:0] rd_byte = 8'h00;

  // display model state, owned by the monitor
  int busy_left, st_cnt, xf_cnt, rsp_cnt, rsp_cyc, rdy_cyc, hi_cnt, prev_st_rise;
  int w_bad, oe_bad, stab_bad, per_bad, per_n, viol;
  logic [6:0] ac;
  logic prev_en, prev_rdy, prev_st_valid, last_rs, last_rw, hi_oe;
  logic [7:0] last_db, hi_db, rsp_d;
  logic rsp_to;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign lcd_db_i = (!lcd_rs_o && lcd_rw_o) ? {busy_left != 0, ac} :
                    (lcd_rs_o && lcd_rw_o)  ? rd_byte : 8'h00;

  lcd_host_drv #(.CW(4), .LONG_DLY(LONG), .SHORT_DLY(SHORT), .POLL_MAX(PMAX)) u_lcd_host_drv (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_rs_i, .req_rw_i, .req_data_i,
    .poll_en_i, .t_setup_i(tsu), .t_high_i(thi), .t_hold_i(tho),
    .rsp_valid_o, .rsp_data_o, .rsp_timeout_o, .status_o,
    .lcd_rs_o, .lcd_rw_o, .lcd_en_o, .lcd_db_o, .lcd_db_oe_o, .lcd_db_i
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      busy_left = 0; st_cnt = 0; xf_cnt = 0; rsp_cnt = 0; rsp_cyc = 0; rdy_cyc = 0;
      hi_cnt = 0; prev_st_rise = 0; w_bad = 0; oe_bad = 0; stab_bad = 0; per_bad = 0;
      per_n = 0; viol = 0; ac = 7'd0; prev_en = 1'b0; prev_rdy = 1'b0;
      prev_st_valid = 1'b0; last_rs = 1'b0; last_rw = 1'b0; hi_oe = 1'b0;
      last_db = 8'h00; hi_db = 8'h00; rsp_d = 8'h00; rsp_to = 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) prev_st_valid = 1'b0;
      if (lcd_en_o && !prev_en) begin
        hi_cnt = 1; hi_db = lcd_db_o; hi_oe = lcd_db_oe_o;
        if (lcd_db_oe_o != !lcd_rw_o) oe_bad++;
        if (!lcd_rs_o && lcd_rw_o) begin
          if (prev_st_valid) begin
            per_n++;
            if (cyc - prev_st_rise != int'(tsu) + int'(thi) + int'(tho) + 4) per_bad++;
          end
          prev_st_valid = 1'b1; prev_st_rise = cyc;
        end else prev_st_valid = 1'b0;
      end else if (lcd_en_o) begin
        hi_cnt++;
        if (lcd_db_o != hi_db || lcd_db_oe_o != hi_oe) stab_bad++;
      end
      if (!lcd_en_o && prev_en) begin
        if (hi_cnt != int'(thi) + 1) w_bad++;
        if (!lcd_rs_o && lcd_rw_o) begin
          st_cnt++;
          if (busy_left > 0) busy_left--;
        end else begin
          xf_cnt++;
          last_rs = lcd_rs_o; last_rw = lcd_rw_o; last_db = lcd_db_o;
          if (busy_left != 0) viol++;
          busy_left = busy_n;
          if (lcd_rs_o && !lcd_rw_o) ac = ac + 7'd1;
        end
      end
      if (rsp_valid_o) begin
        rsp_cnt++; rsp_d = rsp_data_o; rsp_to = rsp_timeout_o; rsp_cyc = cyc;
      end
      if (req_ready_o && !prev_rdy) rdy_cyc = cyc;
      prev_en = lcd_en_o; prev_rdy = req_ready_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic rs, input logic rw, input logic [7:0] d, input logic poll);
    bit sreq, tmo, lng;
    int bl0, npoll, exp_gap, st0, xf0, r0;
    logic [6:0] ac0;
    logic [7:0] exp_d, exp_st;
    sreq = !rs && rw;
    lng = !rs && !rw && (d == 8'h01 || d == 8'h02 || d == 8'h03);
    bl0 = busy_left; ac0 = ac;
    tmo = poll && !sreq && (bl0 >= PMAX);
    npoll = (poll && !sreq) ? (tmo ? PMAX : bl0 + 1) : 0;
    exp_d = tmo ? 8'h00 : (rs && rw) ? rd_byte : sreq ? {bl0 != 0, ac0} : 8'h00;
    exp_gap = (tmo || poll) ? 1 : ((lng ? LONG : sreq ? 0 : SHORT) + 2);
    if (sreq) exp_st = {bl0 != 0, ac0};
    else if (poll) exp_st = {tmo, ac0};
    else exp_st = status_o;
    @(posedge clk_i); #1;
    while (!req_ready_o) begin @(posedge clk_i); #1; end
    st0 = st_cnt; xf0 = xf_cnt; r0 = rsp_cnt;
    req_valid_i = 1'b1; req_rs_i = rs; req_rw_i = rw; req_data_i = d; poll_en_i = poll;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
    chk(!req_ready_o, "R11 ready drops after accept", req_ready_o, 0);
    while (rsp_cnt == r0) begin @(posedge clk_i); #1; end
    while (!req_ready_o) begin @(posedge clk_i); #1; end
    @(posedge clk_i); #1;
    chk(rsp_cnt - r0 == 1, "R11 one response", rsp_cnt - r0, 1);
    chk(st_cnt - st0 == npoll + (sreq ? 1 : 0), "R3 R4 R10 status reads", st_cnt - st0, npoll + (sreq ? 1 : 0));
    chk(xf_cnt - xf0 == ((tmo || sreq) ? 0 : 1), "R4 transfer count", xf_cnt - xf0, (tmo || sreq) ? 0 : 1);
    if (!tmo && !sreq) begin
      chk(last_rs == rs && last_rw == rw, "R2 line codes", {last_rs, last_rw}, {rs, rw});
      if (!rw) chk(last_db == d, "R2 write byte", last_db, d);
    end
    chk(rsp_to == tmo, "R4 timeout flag", rsp_to, tmo);
    chk(rsp_d == exp_d, "R9 R10 response data", rsp_d, exp_d);
    chk(rdy_cyc - rsp_cyc == exp_gap, poll ? "R8 ready gap" : "R7 delay gap", rdy_cyc - rsp_cyc, exp_gap);
    chk(status_o == exp_st, "R10 status_o", status_o, exp_st);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(req_ready_o && !lcd_en_o && !lcd_db_oe_o && lcd_rw_o && !rsp_valid_o && status_o == 8'h00,
        "R1 reset state", {req_ready_o, lcd_en_o, lcd_db_oe_o, lcd_rw_o, rsp_valid_o, status_o}, 14'h1200);
    rst_ni = 1'b1;

    // timing sweep with busy runs 0..3
    for (int cfg = 0; cfg < 27; cfg++) begin
      tsu = 4'(cfg % 3); thi = 4'((cfg / 3) % 3); tho = 4'(cfg / 9);
      busy_n = cfg % 4;
      rd_byte = 8'(cfg * 7 + 3);
      run_req(1'b1, 1'b0, 8'(8'h41 + cfg), 1'b1);
      run_req(1'b0, 1'b0, 8'(8'h38 + cfg), 1'b1);
      run_req(1'b1, 1'b1, 8'h00, 1'b1);
      run_req(1'b0, 1'b1, 8'h00, 1'b1);
    end

    // poll limit boundary
    tsu = 4'd1; thi = 4'd1; tho = 4'd1;
    busy_n = PMAX;
    run_req(1'b0, 1'b0, 8'h0C, 1'b1);
    run_req(1'b1, 1'b0, 8'h55, 1'b1);   // R4 timeout after PMAX busy replies
    busy_n = PMAX - 1;
    run_req(1'b1, 1'b0, 8'h66, 1'b1);
    run_req(1'b0, 1'b0, 8'h06, 1'b1);   // R4 PMAX-1 busy replies succeed
    busy_n = 0;
    run_req(1'b0, 1'b0, 8'h06, 1'b1);

    // fixed delays, polling off
    for (int c = 0; c < 8; c++) run_req(1'b0, 1'b0, 8'(c), 1'b0);
    run_req(1'b0, 1'b0, 8'h81, 1'b0);
    run_req(1'b0, 1'b0, 8'hFE, 1'b0);
    run_req(1'b1, 1'b0, 8'h01, 1'b0);
    run_req(1'b1, 1'b0, 8'h02, 1'b0);
    rd_byte = 8'hA5;
    run_req(1'b1, 1'b1, 8'h00, 1'b0);
    run_req(1'b0, 1'b1, 8'h00, 1'b0);

    chk(w_bad == 0, "R5 strobe width", w_bad, 0);
    chk(oe_bad == 0, "R2 output enable", oe_bad, 0);
    chk(stab_bad == 0, "R2 stable while high", stab_bad, 0);
    chk(per_bad == 0 && per_n > 0, "R6 poll spacing", per_bad, 0);
    chk(viol == 0, "R3 transfer while busy", viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule